// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel words into frames on a synchronous serial link. It watches a serial bit clock that comes from elsewhere and samples it into the system clock domain. On the serial clock edge picked by a polarity input it drives a serial data line and a frame-sync line. Words arrive on a ready/valid input. Each word is right-aligned in a 32-bit bus and goes out most significant bit first.

A frame is made of one phase or two. Each phase has its own word count and its own word size. In a two-phase frame the phase-1 words are followed directly by the phase-2 words, with no gap. Frame-sync marks the start of each frame for one bit period. The first data bit follows frame-sync after a programmable delay of zero, one or two bit periods.

When a word is needed and none is offered, the block sends the previous word again and sets a sticky underrun flag. The configuration inputs are expected to stay constant while a frame is in progress. Changing them during reset is always safe.

Top module: `txfr_top`

## Requirements
- R1: With `dualPhase` = 0 a frame carries only phase-1 words. `frameLen2` and `wordLen2` have no effect on the serial output.
- R2: With `dualPhase` = 1 the phase-1 words are followed by the phase-2 words. The last phase-1 bit and the first phase-2 bit fall in adjacent bit periods, and so do consecutive words within a phase.
- R3: Word-length codes select the word size: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32 bits, and the reserved codes 6 and 7 act as 32. Bits are sent most significant first, starting at bit (size−1) of `inData`. Bus bits above the word size are ignored.
- R4: A frame-length field holds the number of words in its phase minus one, so 0 means one word.
- R5: `dataDelay` 0 puts the first data bit in the frame-sync bit period, 1 puts it one period later, and 2 puts it two periods later. The value 3 behaves as 2. The data line is 0 during the delay periods.
- R6: With `clkPolarity` = 0 the outputs change only after a rising edge of `serClk`. With `clkPolarity` = 1 they change only after a falling edge.
- R7: Frame-sync is active for exactly one bit period at the start of each frame. It is active high when `fsPolarity` = 0 and active low when `fsPolarity` = 1.
- R8: A frame starts on the first drive edge at which the block is idle (or is ending the last bit of a frame) and `inValid` is high. Frames therefore follow each other without idle periods while words keep coming. When idle, the data line is 0.
- R9: A word is consumed on a clock edge where `inReady` and `inValid` are both high. `inReady` is high only in the single clock cycle in which a word is loaded.
- R10: A word load with `inValid` low resends the last loaded word and sets `underrun`. The flag stays set until reset.
- R11: During and straight after reset, `txData` is 0, frame-sync is inactive, `underrun` is 0 and `inReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial bit clock, sampled on `clk` |
| dualPhase | input | 1 | 0: one phase per frame, 1: two phases |
| frameLen1 | input | FL_W | Phase-1 word count minus one |
| frameLen2 | input | FL_W | Phase-2 word count minus one |
| wordLen1 | input | 3 | Phase-1 word-size code |
| wordLen2 | input | 3 | Phase-2 word-size code |
| clkPolarity | input | 1 | 0: drive on rising serial edge, 1: on falling |
| fsPolarity | input | 1 | 0: frame-sync active high, 1: active low |
| dataDelay | input | 2 | Bit periods from frame-sync to the first bit |
| inData | input | 32 | Parallel word, right-aligned |
| inValid | input | 1 | `inData` holds a word |
| inReady | output | 1 | Word taken this cycle |
| txData | output | 1 | Serial data |
| txFrameSync | output | 1 | Frame-sync |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The bench sweeps both phase modes, all four delay codes, two word sizes per phase and one or two words per phase. Each case sends two back-to-back frames, and the clock and frame-sync polarities rotate from case to case. Running every dual-phase setting also with single phase shows whether phase-2 settings leak into one-phase frames. Changing word counts against word sizes tells a per-word bit count apart from a per-phase one. Sampling each bit period at the end of both serial half-periods tells the configured drive edge from the wrong one. Separate runs cover the wider and reserved size codes, using input words whose upper bits are non-zero, and starved inputs that must produce repeated words and a set underrun flag.

// File: rtl/txfr_pkg.sv
package txfr_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic             fsSet;
    logic             fsClr;
    logic             loadWord;
    logic             shiftBit;
    logic             clearData;
    logic [LEN_W-1:0] loadLen;
  } txStrobe_t;

  function automatic logic [LEN_W-1:0] wordBits(input logic [2:0] code);
    case (code)
      3'd0:    wordBits = LEN_W'(8);
      3'd1:    wordBits = LEN_W'(12);
      3'd2:    wordBits = LEN_W'(16);
      3'd3:    wordBits = LEN_W'(20);
      3'd4:    wordBits = LEN_W'(24);
      default: wordBits = LEN_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/txfr_ctrl.sv
module txfr_ctrl
  import txfr_pkg::*;
#(
  parameter int FL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            driveEdge,
  input  logic            inValid,
  input  logic            dualPhase,
  input  logic [FL_W-1:0] frameLen1,
  input  logic [FL_W-1:0] frameLen2,
  input  logic [2:0]      wordLen1,
  input  logic [2:0]      wordLen2,
  input  logic [1:0]      dataDelay,
  output txStrobe_t       strobe,
  output logic            inReady
);
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_DATA} state_t;

  state_t           state, stateNx;
  logic             phase2, phase2Nx;
  logic [FL_W-1:0]  wordsLeft, wordsNx;
  logic [LEN_W-1:0] bitsLeft, bitsNx;
  logic [1:0]       delayLeft, delayNx;
  logic [LEN_W-1:0] len1, len2;
  logic [1:0]       effDelay;
  logic             frameDone, startFrame;

  assign len1       = wordBits(wordLen1);
  assign len2       = wordBits(wordLen2);
  assign effDelay   = (dataDelay == 2'd3) ? 2'd2 : dataDelay;
  assign frameDone  = (state == ST_DATA) && (bitsLeft == '0) && (wordsLeft == '0)
                      && (phase2 || !dualPhase);
  assign startFrame = driveEdge && inValid && ((state == ST_IDLE) || frameDone);

  always_comb begin
    strobe    = '0;
    stateNx   = state;
    phase2Nx  = phase2;
    wordsNx   = wordsLeft;
    bitsNx    = bitsLeft;
    delayNx   = delayLeft;
    if (driveEdge) begin
      strobe.fsClr = 1'b1;
      if (startFrame) begin
        strobe.fsSet = 1'b1;
        phase2Nx     = 1'b0;
        wordsNx      = frameLen1;
        if (effDelay == 2'd0) begin
          strobe.loadWord = 1'b1;
          strobe.loadLen  = len1;
          stateNx         = ST_DATA;
        end else begin
          strobe.clearData = 1'b1;
          delayNx          = effDelay - 2'd1;
          stateNx          = ST_DELAY;
        end
      end else begin
        case (state)
          ST_DELAY: begin
            if (delayLeft == 2'd0) begin
              strobe.loadWord = 1'b1;
              strobe.loadLen  = len1;
              stateNx         = ST_DATA;
            end else begin
              delayNx = delayLeft - 2'd1;
            end
          end
          ST_DATA: begin
            if (bitsLeft != '0) begin
              strobe.shiftBit = 1'b1;
              bitsNx          = bitsLeft - LEN_W'(1);
            end else if (wordsLeft != '0) begin
              strobe.loadWord = 1'b1;
              strobe.loadLen  = phase2 ? len2 : len1;
              wordsNx         = wordsLeft - FL_W'(1);
            end else if (!phase2 && dualPhase) begin
              strobe.loadWord = 1'b1;
              strobe.loadLen  = len2;
              phase2Nx        = 1'b1;
              wordsNx         = frameLen2;
            end else begin
              strobe.clearData = 1'b1;
              stateNx          = ST_IDLE;
            end
          end
          default: strobe.clearData = 1'b1;
        endcase
      end
      if (strobe.loadWord) bitsNx = strobe.loadLen - LEN_W'(1);
    end
  end

  assign inReady = strobe.loadWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase2    <= 1'b0;
      wordsLeft <= '0;
      bitsLeft  <= '0;
      delayLeft <= '0;
    end else begin
      state     <= stateNx;
      phase2    <= phase2Nx;
      wordsLeft <= wordsNx;
      bitsLeft  <= bitsNx;
      delayLeft <= delayNx;
    end
  end

  AST_WORD_MIN_BITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |=> bitsLeft >= LEN_W'(7)); // R3
  AST_PHASE2_ONLY_DUAL: assert property (@(posedge clk) disable iff (!rstN)
    phase2 |-> dualPhase); // R1
  AST_READY_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> driveEdge && (state != ST_IDLE || inValid)); // R9
endmodule

// File: rtl/txfr_datapath.sv
module txfr_datapath
  import txfr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              txBit,
  output logic              fsActive,
  output logic              underrun
);
  localparam logic [LEN_W-1:0] WORD_W_L = LEN_W'(WORD_W);

  logic [WORD_W-1:0] shReg, lastWord, wordSrc, aligned;
  logic [LEN_W-1:0]  shiftAmt;

  assign wordSrc  = inValid ? inData : lastWord;
  assign shiftAmt = WORD_W_L - strobe.loadLen;
  assign aligned  = wordSrc << shiftAmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      lastWord <= '0;
      txBit    <= 1'b0;
      fsActive <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (strobe.loadWord) begin
        txBit    <= aligned[WORD_W-1];
        shReg    <= aligned << 1;
        lastWord <= wordSrc;
        if (!inValid) underrun <= 1'b1;
      end else if (strobe.shiftBit) begin
        txBit <= shReg[WORD_W-1];
        shReg <= shReg << 1;
      end else if (strobe.clearData) begin
        txBit <= 1'b0;
      end
      if (strobe.fsSet)      fsActive <= 1'b1;
      else if (strobe.fsClr) fsActive <= 1'b0;
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun); // R10
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> !$past(inValid)); // R10
endmodule

// File: rtl/txfr_top.sv
module txfr_top
  import txfr_pkg::*;
#(
  parameter int FL_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              dualPhase,
  input  logic [FL_W-1:0]   frameLen1,
  input  logic [FL_W-1:0]   frameLen2,
  input  logic [2:0]        wordLen1,
  input  logic [2:0]        wordLen2,
  input  logic              clkPolarity,
  input  logic              fsPolarity,
  input  logic [1:0]        dataDelay,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              txData,
  output logic              txFrameSync,
  output logic              underrun
);
  logic      serQ, serQ2, driveEdge, fsActive;
  txStrobe_t strobe;

  always_ff @(posedge clk) begin
    serQ  <= serClk;
    serQ2 <= serQ;
  end

  assign driveEdge   = clkPolarity ? (serQ2 & ~serQ) : (serQ & ~serQ2);
  assign txFrameSync = fsActive ^ fsPolarity;

  txfr_ctrl #(.FL_W(FL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .driveEdge(driveEdge), .inValid(inValid),
    .dualPhase(dualPhase), .frameLen1(frameLen1), .frameLen2(frameLen2),
    .wordLen1(wordLen1), .wordLen2(wordLen2), .dataDelay(dataDelay),
    .strobe(strobe), .inReady(inReady)
  );

  txfr_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inValid(inValid),
    .txBit(txData), .fsActive(fsActive), .underrun(underrun)
  );

  AST_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(driveEdge) |-> $stable(txData) && $stable(fsActive)); // R6
endmodule

// File: tb/txfr_top_tb_top.sv
`timescale 1ns/1ps
module txfr_top_tb_top;
  localparam int HALF = 3;
  localparam int MAXP = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        dualPhase = 1'b0;
  logic [6:0]  frameLen1 = '0, frameLen2 = '0;
  logic [2:0]  wordLen1 = '0, wordLen2 = '0;
  logic        clkPolarity = 1'b0, fsPolarity = 1'b0;
  logic [1:0]  dataDelay = '0;
  logic [31:0] inData;
  logic        inValid, inReady, txData, txFrameSync, underrun;

  logic [31:0] wordMem [0:63];
  int          wIdx, nGiven, caseNum;
  int          checks, fails;
  bit          expFs [0:MAXP-1];
  bit          expData [0:MAXP-1];

  always #2 clk = ~clk;

  txfr_top dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .dualPhase(dualPhase),
    .frameLen1(frameLen1), .frameLen2(frameLen2), .wordLen1(wordLen1),
    .wordLen2(wordLen2), .clkPolarity(clkPolarity), .fsPolarity(fsPolarity),
    .dataDelay(dataDelay), .inData(inData), .inValid(inValid),
    .inReady(inReady), .txData(txData), .txFrameSync(txFrameSync),
    .underrun(underrun)
  );

  always_comb begin
    inValid = (wIdx < nGiven);
    inData  = (wIdx < 64) ? wordMem[wIdx] : 32'h0;
  end

  always @(posedge clk) begin
    if (!rstN) wIdx <= 0;
    else if (inValid && inReady) wIdx <= wIdx + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s case %0d: actual %0h expected %0h", req, caseNum, act, exp);
    end
  endtask

  function automatic int sizeOf(input int code);
    return (code <= 4) ? 8 + 4 * code : 32;
  endfunction

  task automatic runCase(input bit dual, input int fl1, input int fl2, input int wl1,
                         input int wl2, input int dly, input bit cp, input bit fp,
                         input int nFrames, input int shortBy);
    int needed, p, wi, nPer, eff, cnt, len;
    logic [31:0] w, lastW;
    rstN = 1'b0;
    dualPhase = dual; frameLen1 = 7'(fl1); frameLen2 = 7'(fl2);
    wordLen1 = 3'(wl1); wordLen2 = 3'(wl2); dataDelay = 2'(dly);
    clkPolarity = cp; fsPolarity = fp; serClk = cp;
    needed = nFrames * ((fl1 + 1) + (dual ? fl2 + 1 : 0));
    for (int k = 0; k < 64; k++)
      wordMem[k] = (32'h9E3779B9 * 32'(k + 1 + caseNum * 7)) ^ 32'hC3A55A3C;
    nGiven = needed - shortBy;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 txData", 32'(txData), 32'd0);
    check("R11 frame-sync", 32'(txFrameSync), 32'(fp));
    check("R11 underrun", 32'(underrun), 32'd0);
    check("R11 inReady", 32'(inReady), 32'd0);

    for (int i = 0; i < MAXP; i++) begin expFs[i] = 0; expData[i] = 0; end
    eff = (dly == 3) ? 2 : dly;
    p = 0; wi = 0; lastW = '0;
    for (int f = 0; f < nFrames; f++) begin
      expFs[p] = 1'b1;
      p += eff;
      for (int ph = 0; ph < (dual ? 2 : 1); ph++) begin
        cnt = (ph != 0) ? fl2 + 1 : fl1 + 1;
        len = (ph != 0) ? sizeOf(wl2) : sizeOf(wl1);
        for (int wd = 0; wd < cnt; wd++) begin
          if (wi < nGiven) begin w = wordMem[wi]; lastW = w; end
          else w = lastW;
          wi++;
          for (int b = len - 1; b >= 0; b--) begin expData[p] = w[b]; p++; end
        end
      end
    end
    nPer = p + 3;

    for (int q = 0; q < nPer; q++) begin
      serClk = ~cp;
      repeat (HALF) @(negedge clk);
      // R1 R2 R3 R4 R5 R8 serial data; R6 checked in both halves
      check("R1 R2 R3 R4 R5 R8 data", 32'(txData), 32'(expData[q]));
      check("R7 frame-sync", 32'(txFrameSync), 32'(expFs[q] ^ fp));
      serClk = cp;
      repeat (HALF) @(negedge clk);
      check("R6 data held", 32'(txData), 32'(expData[q]));
      check("R6 frame-sync held", 32'(txFrameSync), 32'(expFs[q] ^ fp));
    end
    check("R10 underrun flag", 32'(underrun), 32'(shortBy > 0));
    check("R9 words consumed", 32'(wIdx), 32'(nGiven));
    caseNum++;
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; caseNum = 0; nGiven = 0;
    for (int d = 0; d < 2; d++)
      for (int dl = 0; dl < 4; dl++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            for (int f1 = 0; f1 < 2; f1++)
              for (int f2 = 0; f2 < 2; f2++)
                runCase(d[0], f1, f2, 2 * a, 2 * b, dl,
                        caseNum[0], caseNum[1], 2, 0);
    // R3 wide and reserved size codes
    runCase(1'b1, 1, 0, 5, 7, 3, 1'b0, 1'b1, 2, 0);
    runCase(1'b1, 0, 1, 1, 3, 2, 1'b1, 1'b0, 2, 0);
    runCase(1'b0, 2, 0, 4, 6, 1, 1'b0, 1'b0, 1, 0);
    // R10 starvation
    runCase(1'b0, 2, 0, 0, 0, 0, 1'b0, 1'b0, 1, 1);
    runCase(1'b1, 1, 1, 2, 0, 1, 1'b1, 1'b1, 1, 2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule